// File: doc/BRIEF.md
# SD Card Data FIFO with Byte Packing

This block sits between a host register port and the byte-wide data side of an SD card interface. The host moves 32-bit words through a data register, and those words pass through a circular word FIFO. In the card-to-host direction, the block takes bytes from the card port and packs them into words, lowest byte lane first. In the host-to-card direction, it takes words out of the FIFO and sends their bytes one at a time, lowest byte first. Serialising the DAT lines and generating CRC16 are handled elsewhere.

The length of a transfer is given in bytes. The host writes a block size and then a block count. Writing the block count loads a byte down-counter with the product of the two. The card port stops handshaking when that counter reaches zero. If a read transfer ends part way through a word, the partial word is still pushed into the FIFO. A debug register reports the FIFO fill level and a small state code, and the state code changes to "data mode" when a transfer completes. Only one direction runs at a time. The read direction bit takes priority over the write direction bit.

Top module: `sdp_data_path`

## Requirements
- R1: After reset, the FIFO is empty, `card_rx_ready` and `card_tx_valid` are low, and the debug register (address 0x34) reads 0x0000C60F.
- R2: The FIFO holds DEPTH (16) words in arrival order. A push while the FIFO is full is dropped. A data-register read while the FIFO is empty returns zero and leaves the level unchanged.
- R3: The block-size register is at address 0x3C and holds 16 bits. The block-count register is at address 0x50 and holds 9 bits. Writing the block-count register loads the remaining byte count with the block count times the block size. The same write discards any partially packed or unpacked word.
- R4: `card_rx_ready` is high only under all of these conditions: the read direction is selected, the remaining count is nonzero, the FIFO is not full, and `card_data_ready` is high. The k-th accepted byte of a word goes to bits [8k+7:8k], for k = 0 to 3. A complete word is pushed on its fourth byte.
- R5: When the last byte of a read transfer completes only part of a word, that word is pushed with its unused upper bytes set to zero.
- R6: In the write direction, a word is popped when no bytes are pending. Its bytes are then offered on `card_tx_data`, starting with bits [7:0]. Each accepted byte decrements the remaining count by one. Bytes beyond the end of the count are discarded.
- R7: When the last byte of a transfer is handshaked in either direction, debug bits [3:0] become 1.
- R8: Debug bits [8:4] always read the current FIFO level.
- R9: A read of the data register (address 0x40) returns the FIFO head and pops it. A write to the data register pushes the write data, except in the read direction, where the write is ignored. A host pop takes priority over a pop by the transfer engine in the same cycle.
- R10: A write to the debug register stores bits [31:9] and [3:0] of the write data. If the written value of bits [3:0] is 0xF, those bits are stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (a read of the data register pops the FIFO) |
| reg_addr | input | 8 | Host register byte address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational from reg_addr |
| dir_rd | input | 1 | Card-to-host direction select |
| dir_wr | input | 1 | Host-to-card direction select |
| card_data_ready | input | 1 | Card has read data available |
| card_rx_valid | input | 1 | Card byte valid |
| card_rx_data | input | 8 | Card byte into the block |
| card_rx_ready | output | 1 | Block accepts a card byte |
| card_tx_valid | output | 1 | Block offers a byte to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card accepts the offered byte |

## Verification
A wrong FIFO pointer or level shows up at once on debug bits [8:4] and on the ready handshake. The same fault also shows up at the next data-register read as a word out of order. A fault in the packing lane counter or in the byte counter changes the content of the next pushed word, or makes the card handshake stop one byte early or late. Either effect is visible within one byte time. The reference model predicts every output in every cycle, so a divergence is reported in the cycle in which it first reaches a port.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

   // host register map (byte addresses)
   localparam logic [7:0] ADR_DBG   = 8'h34;
   localparam logic [7:0] ADR_BSIZE = 8'h3C;
   localparam logic [7:0] ADR_DATA  = 8'h40;
   localparam logic [7:0] ADR_BCNT  = 8'h50;

   // debug register reset image and state codes
   localparam logic [31:0] DBG_RESET   = 32'h0000_C60F;
   localparam logic [3:0]  ST_DATAMODE = 4'h1;
   localparam logic [3:0]  ST_PWRDOWN  = 4'hF;

   typedef enum logic [1:0] {
      XM_IDLE  = 2'd0,
      XM_READ  = 2'd1,
      XM_WRITE = 2'd2
   } xfer_mode_e;

endpackage

// File: rtl/sdp_fifo.sv
module sdp_fifo #(
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned W         = 32,
   parameter bit          CLEAR_MEM = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic                     pop,
   input  logic [W-1:0]             wdata,
   output logic [W-1:0]             rdata,
   output logic [$clog2(DEPTH):0]   level,
   output logic                     full,
   output logic                     empty
);
   localparam int unsigned PW = $clog2(DEPTH);
   localparam int unsigned LW = PW + 1;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("sdp_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [LW-1:0] cnt_q;
   logic          push_ok, pop_ok;

   assign full    = (cnt_q == LW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign level   = cnt_q;
   assign rdata   = empty ? '0 : mem[rp_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + 1'b1;
         if (pop_ok)  rp_q <= rp_q + 1'b1;
         cnt_q <= cnt_q + LW'(push_ok) - LW'(pop_ok);
      end
   end

   generate
      if (CLEAR_MEM) begin : g_mem_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
            end else if (push_ok) begin
               mem[wp_q] <= wdata;
            end
         end
      end else begin : g_mem_plain
         always_ff @(posedge clk) begin
            if (push_ok) mem[wp_q] <= wdata;
         end
      end
   endgenerate

   // R2
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LW'(DEPTH));
   // R2
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);
   // R2
   empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (rdata == '0));

endmodule

// File: rtl/sdp_rx_pack.sv
module sdp_rx_pack (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        clr,
   input  logic        rem_nz,
   input  logic        rem_one,
   input  logic        fifo_full,
   input  logic        card_rdy,
   input  logic        rx_valid,
   input  logic [7:0]  rx_data,
   output logic        rx_ready,
   output logic        take,
   output logic        push,
   output logic [31:0] push_word
);
   logic [1:0]  lane_q;
   logic [31:0] acc_q;
   logic [31:0] merged;

   assign rx_ready = en & rem_nz & ~fifo_full & card_rdy;
   assign take     = rx_ready & rx_valid;

   generate
      for (genvar b = 0; b < 4; b++) begin : g_lane
         assign merged[8*b +: 8] = (lane_q == 2'(b)) ? rx_data : acc_q[8*b +: 8];
      end
   endgenerate

   assign push      = take & ((lane_q == 2'd3) | rem_one);
   assign push_word = merged;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         lane_q <= '0;
         acc_q  <= '0;
      end else if (take) begin
         if (push) begin
            lane_q <= '0;
            acc_q  <= '0;
         end else begin
            lane_q <= lane_q + 1'b1;
            acc_q  <= merged;
         end
      end
   end

   // R4
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> (!fifo_full && rem_nz && card_rdy));

endmodule

// File: rtl/sdp_tx_unpack.sv
module sdp_tx_unpack (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        clr,
   input  logic        rem_nz,
   input  logic        rem_one,
   input  logic        fifo_empty,
   input  logic        host_pop,
   input  logic [31:0] pop_word,
   input  logic        tx_ready,
   output logic        pop_req,
   output logic        tx_valid,
   output logic [7:0]  tx_data,
   output logic        sent
);
   logic [2:0]  left_q;
   logic [31:0] sh_q;

   assign pop_req  = en & (left_q == '0) & rem_nz & ~fifo_empty & ~host_pop;
   assign tx_valid = en & (left_q != '0);
   assign tx_data  = sh_q[7:0];
   assign sent     = tx_valid & tx_ready;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         left_q <= '0;
         sh_q   <= '0;
      end else if (pop_req) begin
         left_q <= 3'd4;
         sh_q   <= pop_word;
      end else if (sent) begin
         sh_q   <= sh_q >> 8;
         left_q <= rem_one ? 3'd0 : left_q - 1'b1;
      end
   end

   // R6
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !clr) |=> $stable(tx_data));
   // R6
   tx_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= 3'd4);

endmodule

// File: rtl/sdp_data_path.sv
module sdp_data_path #(
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned BSZ_W     = 16,
   parameter int unsigned BCNT_W    = 9,
   parameter bit          CLEAR_MEM = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [7:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        dir_rd,
   input  logic        dir_wr,
   input  logic        card_data_ready,
   input  logic        card_rx_valid,
   input  logic [7:0]  card_rx_data,
   output logic        card_rx_ready,
   output logic        card_tx_valid,
   output logic [7:0]  card_tx_data,
   input  logic        card_tx_ready
);
   import sdp_pkg::*;

   localparam int unsigned CNT_W = BSZ_W + BCNT_W;
   localparam int unsigned LW    = $clog2(DEPTH) + 1;

   initial begin
      assert (LW <= 5) else $error("sdp_data_path: level must fit debug field");
      assert (BSZ_W <= 32 && BCNT_W <= 32 && CNT_W <= 32)
         else $error("sdp_data_path: count widths too large");
   end

   xfer_mode_e mode;
   assign mode = dir_rd ? XM_READ : (dir_wr ? XM_WRITE : XM_IDLE);

   // register decode
   logic host_pop, host_push, bsz_wr, load, dbg_wr;
   assign host_pop  = reg_rd & (reg_addr == ADR_DATA);
   assign host_push = reg_wr & (reg_addr == ADR_DATA) & (mode != XM_READ);
   assign bsz_wr    = reg_wr & (reg_addr == ADR_BSIZE);
   assign load      = reg_wr & (reg_addr == ADR_BCNT);
   assign dbg_wr    = reg_wr & (reg_addr == ADR_DBG);

   logic [BSZ_W-1:0]  bsize_q;
   logic [BCNT_W-1:0] bcnt_q;
   logic [CNT_W-1:0]  rem_q;
   logic [31:9]       dbg_hi_q;
   logic [3:0]        dbg_st_q;

   logic rem_nz, rem_one;
   assign rem_nz  = (rem_q != '0);
   assign rem_one = (rem_q == CNT_W'(1));

   // FIFO
   logic [31:0]   f_rdata, f_wdata;
   logic [LW-1:0] f_level;
   logic          f_full, f_empty, f_push, f_pop;

   // engines
   logic        rx_take, rx_push;
   logic [31:0] rx_word;
   logic        tx_pop, tx_sent;

   sdp_rx_pack u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (mode == XM_READ),
      .clr       (load),
      .rem_nz    (rem_nz),
      .rem_one   (rem_one),
      .fifo_full (f_full),
      .card_rdy  (card_data_ready),
      .rx_valid  (card_rx_valid),
      .rx_data   (card_rx_data),
      .rx_ready  (card_rx_ready),
      .take      (rx_take),
      .push      (rx_push),
      .push_word (rx_word)
   );

   sdp_tx_unpack u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (mode == XM_WRITE),
      .clr        (load),
      .rem_nz     (rem_nz),
      .rem_one    (rem_one),
      .fifo_empty (f_empty),
      .host_pop   (host_pop),
      .pop_word   (f_rdata),
      .tx_ready   (card_tx_ready),
      .pop_req    (tx_pop),
      .tx_valid   (card_tx_valid),
      .tx_data    (card_tx_data),
      .sent       (tx_sent)
   );

   assign f_push  = host_push | rx_push;
   assign f_wdata = rx_push ? rx_word : reg_wdata;
   assign f_pop   = host_pop | tx_pop;

   sdp_fifo #(
      .DEPTH     (DEPTH),
      .W         (32),
      .CLEAR_MEM (CLEAR_MEM)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (f_push),
      .pop   (f_pop),
      .wdata (f_wdata),
      .rdata (f_rdata),
      .level (f_level),
      .full  (f_full),
      .empty (f_empty)
   );

   // byte counter and transfer length registers
   logic step, done;
   assign step = rx_take | tx_sent;
   assign done = step & rem_one & ~load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bsize_q <= '0;
         bcnt_q  <= '0;
         rem_q   <= '0;
      end else begin
         if (bsz_wr) bsize_q <= reg_wdata[BSZ_W-1:0];
         if (load) begin
            bcnt_q <= reg_wdata[BCNT_W-1:0];
            rem_q  <= CNT_W'(reg_wdata[BCNT_W-1:0]) * CNT_W'(bsize_q);
         end else if (step) begin
            rem_q  <= rem_q - 1'b1;
         end
      end
   end

   // debug register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dbg_hi_q <= DBG_RESET[31:9];
         dbg_st_q <= DBG_RESET[3:0];
      end else if (dbg_wr) begin
         dbg_hi_q <= reg_wdata[31:9];
         dbg_st_q <= (reg_wdata[3:0] == ST_PWRDOWN) ? 4'h0 : reg_wdata[3:0];
      end else if (done) begin
         dbg_st_q <= ST_DATAMODE;
      end
   end

   // read mux
   logic [31:0] dbg_view;
   assign dbg_view = {dbg_hi_q, 5'(f_level), dbg_st_q};

   always_comb begin
      unique case (reg_addr)
         ADR_DATA:  reg_rdata = f_rdata;
         ADR_DBG:   reg_rdata = dbg_view;
         ADR_BSIZE: reg_rdata = 32'(bsize_q);
         ADR_BCNT:  reg_rdata = 32'(bcnt_q);
         default:   reg_rdata = '0;
      endcase
   end

   // R7
   done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rem_q) != '0 && rem_q == '0 && !$past(load) && !$past(dbg_wr))
      |-> (dbg_st_q == ST_DATAMODE));
   // R4
   one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(card_rx_ready && card_tx_valid));
   // R9
   read_mode_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_rd && !rx_push) |-> !f_push);

endmodule

// File: tb/test_sdp_data_path.sv
module test_sdp_data_path;
   localparam time CYC = 10ns;
   localparam logic [7:0] A_DBG = 8'h34, A_BSZ = 8'h3C, A_DATA = 8'h40, A_BCNT = 8'h50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 0, reg_rd = 0;
   logic [7:0] reg_addr = A_DBG;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic dir_rd = 0, dir_wr = 0, card_data_ready = 0, card_rx_valid = 0;
   logic [7:0] card_rx_data = '0;
   logic card_rx_ready, card_tx_valid, card_tx_ready = 0;
   logic [7:0] card_tx_data;

   always #(CYC/2) clk = ~clk;

   sdp_data_path i_sdp_data_path (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .dir_rd(dir_rd), .dir_wr(dir_wr), .card_data_ready(card_data_ready),
      .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
      .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
      .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready));

   int checks = 0, errs = 0;
   bit finished = 0;

   // reference model state
   int unsigned q[$];
   int rem = 0, pk_n = 0, un_n = 0, bsz = 0, bct = 0;
   logic [31:0] pk_w = 0, un_w = 0, dbg = 32'h0000C60F;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] m_rdata();
      case (reg_addr)
         A_DATA: return (q.size() > 0) ? q[0] : 32'h0;
         A_DBG:  return {dbg[31:9], 5'(q.size()), dbg[3:0]};
         A_BSZ:  return 32'(bsz);
         A_BCNT: return 32'(bct);
         default: return 32'h0;
      endcase
   endfunction

   // one cycle: compare every output against the model, then advance the model
   task automatic tick();
      bit rd_m, wr_m, e_rx, e_tv, take, sent, hp, hpush, epop, do_push, done, ld;
      int lvl0;
      logic [31:0] head, pv, merged;
      #1;
      rd_m = dir_rd; wr_m = dir_wr && !dir_rd;
      e_rx = rd_m && rem != 0 && q.size() < 16 && card_data_ready;
      e_tv = wr_m && un_n != 0;
      chk("R4 rx_ready", 32'(card_rx_ready), 32'(e_rx));
      chk("R6 tx_valid", 32'(card_tx_valid), 32'(e_tv));
      if (e_tv) chk("R6 tx_data", 32'(card_tx_data), 32'(un_w[7:0]));
      chk((reg_addr == A_DATA) ? "R9 rdata" : (reg_addr == A_DBG) ? "R8 rdata" : "R3 rdata",
          reg_rdata, m_rdata());
      hp = reg_rd && reg_addr == A_DATA;
      hpush = reg_wr && reg_addr == A_DATA && !dir_rd;
      ld = reg_wr && reg_addr == A_BCNT;
      take = e_rx && card_rx_valid;
      sent = e_tv && card_tx_ready;
      lvl0 = q.size();
      head = (lvl0 > 0) ? q[0] : 0;
      epop = wr_m && un_n == 0 && rem != 0 && lvl0 > 0 && !hp;
      do_push = 0; pv = 0;
      if (take) begin
         merged = pk_w | (32'(card_rx_data) << (8 * pk_n));
         if (pk_n == 3 || rem == 1) begin
            do_push = 1; pv = merged; pk_n = 0; pk_w = 0;
         end else begin
            pk_w = merged; pk_n++;
         end
      end
      if (hpush) begin do_push = 1; pv = reg_wdata; end
      if ((hp || epop) && lvl0 > 0) void'(q.pop_front());
      if (do_push && lvl0 < 16) q.push_back(pv);
      if (epop) begin un_w = head; un_n = 4; end
      if (sent) begin
         un_w = un_w >> 8; un_n--;
         if (rem == 1) un_n = 0;
      end
      done = (take || sent) && rem == 1 && !ld;
      if (take || sent) rem--;
      if (done) dbg[3:0] = 4'h1;
      if (reg_wr) begin
         case (reg_addr)
            A_BSZ: bsz = int'(reg_wdata[15:0]);
            A_BCNT: begin
               bct = int'(reg_wdata[8:0]); rem = bct * bsz;
               pk_n = 0; pk_w = 0; un_n = 0; un_w = 0;
            end
            A_DBG: begin
               dbg = reg_wdata;
               if (reg_wdata[3:0] == 4'hF) dbg[3:0] = 4'h0;
            end
            default: ;
         endcase
      end
      @(posedge clk); @(negedge clk);
      reg_wr = 0; reg_rd = 0; reg_addr = A_DBG;
   endtask

   task automatic hwrite(logic [7:0] a, logic [31:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
   endtask

   task automatic hread(logic [7:0] a, output logic [31:0] d);
      reg_rd = 1; reg_addr = a; #1 d = reg_rdata; tick();
   endtask

   initial begin : watchdog
      #(CYC * 150000);
      if (!finished) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] v;
      logic [7:0] got[$];
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      reg_addr = A_DBG; #1;
      chk("R1 debug", reg_rdata, 32'h0000C60F);
      chk("R1 rx_ready", 32'(card_rx_ready), 0);
      chk("R1 tx_valid", 32'(card_tx_valid), 0);
      tick();

      // R2 fill beyond capacity in idle mode, drain in order, read empty
      for (int i = 0; i < 17; i++) hwrite(A_DATA, 32'hA000_0000 + i);
      hread(A_DBG, v); chk("R2 level full", 32'(v[8:4]), 16);
      for (int i = 0; i < 16; i++) begin
         hread(A_DATA, v); chk("R2 order", v, 32'hA000_0000 + i);
      end
      hread(A_DATA, v); chk("R2 empty pop zero", v, 0);
      hread(A_DBG, v); chk("R2 level after empty pop", 32'(v[8:4]), 0);

      // R10 debug write and power-down code
      hwrite(A_DBG, 32'h1234_567F);
      hread(A_DBG, v); chk("R10 pwrdown masked", v, 32'h1234_5600);
      hwrite(A_DBG, 32'h0000_0AB3);
      hread(A_DBG, v); chk("R10 plain store", v, 32'h0000_0A03);

      // R9 data writes ignored in read direction
      dir_rd = 1;
      hwrite(A_DATA, 32'hDEAD_BEEF);
      hread(A_DBG, v); chk("R9 ignored write level", 32'(v[8:4]), 0);

      // R3 R4 R5 read of 6 bytes: one full word, one partial word
      hwrite(A_BSZ, 6);
      hwrite(A_BCNT, 1);
      hread(A_BSZ, v); chk("R3 bsize", v, 6);
      card_data_ready = 0; card_rx_valid = 1; card_rx_data = 8'h01;
      #1 chk("R4 card not ready", 32'(card_rx_ready), 0);
      tick();
      card_data_ready = 1;
      k = 1;
      for (int c = 0; c < 40 && k <= 6; c++) begin
         card_rx_data = 8'(k);
         #1 if (card_rx_ready) k++;
         tick();
      end
      card_rx_valid = 0;
      tick();
      hread(A_DBG, v);
      chk("R7 data mode", 32'(v[3:0]), 1);
      chk("R8 level two", 32'(v[8:4]), 2);
      hread(A_DATA, v); chk("R4 packed word", v, 32'h0403_0201);
      hread(A_DATA, v); chk("R5 partial word", v, 32'h0000_0605);

      // R2 R4 stall at full: 72 bytes, FIFO takes 64 before host drains
      hwrite(A_DBG, 32'h0);
      hwrite(A_BSZ, 4);
      hwrite(A_BCNT, 18);
      card_rx_valid = 1;
      k = 0;
      for (int c = 0; c < 90; c++) begin
         card_rx_data = 8'(k);
         #1 if (card_rx_ready) k++;
         tick();
      end
      chk("R4 stalled at full", 32'(card_rx_ready), 0);
      chk("R2 bytes accepted", 32'(k), 64);
      for (int w = 0; w < 18; w++) begin
         card_rx_data = 8'(k);
         #1 if (card_rx_ready) k++;
         hread(A_DATA, v);
         chk("R4 stream word", v,
             {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
      end
      card_rx_valid = 0;
      for (int c = 0; c < 4; c++) tick();
      chk("R3 length honoured", 32'(k), 72);
      dir_rd = 0; card_data_ready = 0;
      tick();

      // R6 write 10 bytes from three words; last two bytes discarded
      hwrite(A_DBG, 32'h0);
      hwrite(A_DATA, 32'h4433_2211);
      hwrite(A_DATA, 32'h8877_6655);
      hwrite(A_DATA, 32'hCCBB_AA99);
      hwrite(A_BSZ, 10);
      hwrite(A_BCNT, 1);
      dir_wr = 1;
      for (int c = 0; c < 40; c++) begin
         card_tx_ready = c[0];
         #1 if (card_tx_valid && card_tx_ready) got.push_back(card_tx_data);
         tick();
      end
      card_tx_ready = 0;
      chk("R6 byte count", 32'(got.size()), 10);
      for (int i = 0; i < 10 && i < got.size(); i++)
         chk("R6 byte order", 32'(got[i]), 32'h11 * (i + 1));
      hread(A_DBG, v);
      chk("R7 write done", 32'(v[3:0]), 1);
      chk("R6 fifo drained", 32'(v[8:4]), 0);

      // R9 host pop wins over engine pop in the write direction
      dir_wr = 0;
      hwrite(A_DATA, 32'h0000_0077);
      hwrite(A_DATA, 32'h0000_0088);
      hwrite(A_BSZ, 4);
      hwrite(A_BCNT, 1);
      dir_wr = 1;
      hread(A_DATA, v); chk("R9 host pop priority", v, 32'h0000_0077);
      tick();
      #1 chk("R9 engine got next", 32'(card_tx_data), 32'h88);
      dir_wr = 0;
      tick();

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule